// File: doc/BRIEF.md
# DRAM Initialisation and Refresh Sequencer

This block brings an asynchronous DRAM out of power-up and keeps its rows refreshed. After reset it stays off the DRAM pins for a programmable pause. It then runs a fixed number of CAS-before-RAS (CBR) cycles and raises a ready flag. From then on an interval counter marks when each refresh is due. The sequencer issues one CBR cycle per interval, so the refreshes are spread evenly over the refresh period. The row address comes from the DRAM's internal counter, so the sequencer never drives the address pins.

The sequencer shares the DRAM strobes with a separate access controller. It raises a request and drives RAS and CAS only while the access controller grants the pins. If the grant is delayed, the refreshes that fall due are counted up to a ceiling and then issued back to back. On command the sequencer also parks the DRAM in self refresh by holding both strobes low. On exit it raises both strobes, waits out the precharge time and issues one CBR cycle before it releases the pins.

The parameters are the clock frequency in MHz, the pause in microseconds, the number of initialisation cycles, the number of refresh rows, the refresh period in milliseconds, the pending-refresh ceiling and the strobe timings in clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset, `busReq` stays low and `rasN` and `casN` stay high for at least PAUSE_US*CLK_MHZ clock cycles, which is 20000 with the defaults.
- R2: Exactly INIT_CBR CBR cycles (8 by default) are issued before `initDone` rises. Once high, `initDone` stays high until the next reset.
- R3: Every falling edge of `rasN` comes after `casN` has been low for at least CSR_CYC cycles (2 by default). The strobes therefore always form a CAS-before-RAS sequence.
- R4: After initialisation, one refresh falls due every PERIOD_MS*1000*CLK_MHZ/ROWS cycles, which is 1562 with the defaults. When the grant is free, a window of N intervals holds N refresh cycles, give or take one.
- R5: While the grant is withheld, due refreshes are counted up to MAX_PEND (8 by default) and any further ones are dropped. Once the grant returns, the counted refreshes are issued back to back, one idle cycle apart.
- R6: In a refresh cycle `rasN` is low for RAS_CYC cycles (5 by default). It then stays high for at least RP_CYC cycles (4 by default) before it may fall again.
- R7: `rasN` and `casN` stay high whenever `busReq` is low or the grant has not yet arrived for a new cycle. `busReq` stays high while refresh, initialisation or self-refresh work is outstanding.
- R8: When the sequencer is idle and `selfReq` is high, it lowers `casN`, then `rasN`, and holds both low while `selfReq` stays high. The hold lasts at least SELF_HOLD_CYC cycles (10 by default), even for a short request. `selfActive` is high only while the hold has passed that threshold.
- R9: On leaving self refresh, both strobes rise and stay high for the precharge time. Exactly one CBR cycle follows, and then `busReq` drops. Refreshes that were owed are discarded, and the interval count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| selfReq | input | 1 | High to request self refresh (level) |
| busGrant | input | 1 | Access controller grants the DRAM strobes |
| busReq | output | 1 | Sequencer requests the DRAM strobes |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| initDone | output | 1 | Initialisation sequence completed |
| selfActive | output | 1 | DRAM is held in self refresh past the threshold |

## Verification
The bench measures the gap from reset release to the first CAS fall. A sequencer that counted the pause too short would touch the DRAM early. It counts the CBR cycles before the ready flag, which catches an off-by-one in the initialisation counter. It withholds the grant for many intervals and then checks that the burst that follows is capped at the ceiling; a counter that wraps or does not saturate would give too many or too few cycles. Around self refresh it checks the minimum hold for a one-cycle-long request. It also checks that exactly one CBR follows the exit and that no refresh comes soon after, which exposes a missing post-exit cycle or a stale pending count carried out of self refresh.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    S_PAUSE, S_IDLE, S_CASLEAD, S_RASACT, S_PRECH, S_SELFHOLD
  } seqState_e;

  typedef enum logic [1:0] {
    K_INIT, K_REF, K_SELF, K_POST
  } cycKind_e;

  typedef enum logic [1:0] {
    T_CSR, T_RAS, T_RP, T_SELF
  } timerSel_e;

  typedef struct packed {
    logic      ldTimer;
    timerSel_e timerSel;
    logic      pendDec;
    logic      clrPend;
    logic      initInc;
    logic      holdInterval;
  } rfshStrobe_t;

endpackage

// File: rtl/dram_rfsh_dp.sv
module dram_rfsh_dp
  import dram_rfsh_pkg::*;
#(
  parameter int PAUSE_CYC     = 20000,
  parameter int INTERVAL_CYC  = 1562,
  parameter int INIT_CBR      = 8,
  parameter int MAX_PEND      = 8,
  parameter int CSR_CYC       = 2,
  parameter int RAS_CYC       = 5,
  parameter int RP_CYC        = 4,
  parameter int SELF_HOLD_CYC = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  rfshStrobe_t stb,
  output logic        timerZero,
  output logic        pendAny,
  output logic        initDone
);

  localparam int TW  = $clog2(PAUSE_CYC + SELF_HOLD_CYC + CSR_CYC + RAS_CYC + RP_CYC + 1);
  localparam int IVW = $clog2(INTERVAL_CYC + 1);
  localparam int PW  = $clog2(MAX_PEND + 1);
  localparam int IW  = $clog2(INIT_CBR + 1);

  localparam logic [TW-1:0]  PAUSE_LD = TW'(PAUSE_CYC - 1);
  localparam logic [TW-1:0]  CSR_LD   = TW'(CSR_CYC - 1);
  localparam logic [TW-1:0]  RAS_LD   = TW'(RAS_CYC - 1);
  localparam logic [TW-1:0]  RP_LD    = TW'(RP_CYC - 1);
  localparam logic [TW-1:0]  SELF_LD  = TW'(SELF_HOLD_CYC - 1);
  localparam logic [IVW-1:0] IV_LAST  = IVW'(INTERVAL_CYC - 1);
  localparam logic [PW-1:0]  PEND_MAX = PW'(MAX_PEND);
  localparam logic [IW-1:0]  INIT_MAX = IW'(INIT_CBR);

  logic [TW-1:0]  timer;
  logic [TW-1:0]  loadVal;
  logic [IVW-1:0] ivCnt;
  logic [PW-1:0]  pendCnt;
  logic [IW-1:0]  initCnt;
  logic           tick;
  logic           pendInc;

  always_comb begin
    case (stb.timerSel)
      T_CSR:   loadVal = CSR_LD;
      T_RAS:   loadVal = RAS_LD;
      T_RP:    loadVal = RP_LD;
      default: loadVal = SELF_LD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)               timer <= PAUSE_LD;
    else if (stb.ldTimer)    timer <= loadVal;
    else if (timer != '0)    timer <= timer - 1'b1;
  end
  assign timerZero = (timer == '0);

  assign tick = initDone && !stb.holdInterval && (ivCnt == IV_LAST);

  always_ff @(posedge clk) begin
    if (!rstN || stb.holdInterval) ivCnt <= '0;
    else if (initDone)             ivCnt <= (ivCnt == IV_LAST) ? '0 : ivCnt + 1'b1;
  end

  assign pendInc = tick && ((pendCnt != PEND_MAX) || stb.pendDec);

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrPend) pendCnt <= '0;
    else pendCnt <= pendCnt + PW'(pendInc) - PW'(stb.pendDec);
  end
  assign pendAny = (pendCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN)                               initCnt <= '0;
    else if (stb.initInc && !initDone)       initCnt <= initCnt + 1'b1;
  end
  assign initDone = (initCnt == INIT_MAX);

  // R5
  pend_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= PEND_MAX);

  // R2
  init_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(initDone));

endmodule

// File: rtl/dram_rfsh_ctrl.sv
module dram_rfsh_ctrl
  import dram_rfsh_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        selfReq,
  input  logic        busGrant,
  input  logic        timerZero,
  input  logic        pendAny,
  input  logic        initDone,
  output rfshStrobe_t stb,
  output logic        busReq,
  output logic        rasN,
  output logic        casN,
  output logic        selfActive
);

  seqState_e state, nxt;
  cycKind_e  kind, kindN;
  logic      want;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_PAUSE;
      kind  <= K_INIT;
    end else begin
      state <= nxt;
      kind  <= kindN;
    end
  end

  always_comb begin
    stb   = '0;
    nxt   = state;
    kindN = kind;
    want  = !initDone || selfReq || pendAny;
    case (state)
      S_PAUSE: if (timerZero) nxt = S_IDLE;
      S_IDLE: if (want && busGrant) begin
        nxt          = S_CASLEAD;
        stb.ldTimer  = 1'b1;
        stb.timerSel = T_CSR;
        if (!initDone)    kindN = K_INIT;
        else if (selfReq) kindN = K_SELF;
        else              kindN = K_REF;
      end
      S_CASLEAD: if (timerZero) begin
        stb.ldTimer = 1'b1;
        if (kind == K_SELF) begin
          nxt          = S_SELFHOLD;
          stb.timerSel = T_SELF;
        end else begin
          nxt          = S_RASACT;
          stb.timerSel = T_RAS;
        end
      end
      S_RASACT: if (timerZero) begin
        nxt          = S_PRECH;
        stb.ldTimer  = 1'b1;
        stb.timerSel = T_RP;
      end
      S_SELFHOLD: begin
        stb.clrPend      = 1'b1;
        stb.holdInterval = 1'b1;
        if (timerZero && !selfReq) begin
          nxt          = S_PRECH;
          stb.ldTimer  = 1'b1;
          stb.timerSel = T_RP;
        end
      end
      S_PRECH: if (timerZero) begin
        case (kind)
          K_INIT: begin stb.initInc = 1'b1; nxt = S_IDLE; end
          K_REF:  begin stb.pendDec = 1'b1; nxt = S_IDLE; end
          K_SELF: begin
            nxt          = S_CASLEAD;
            kindN        = K_POST;
            stb.ldTimer  = 1'b1;
            stb.timerSel = T_CSR;
          end
          default: nxt = S_IDLE;
        endcase
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign busReq     = (state != S_PAUSE) && ((state != S_IDLE) || want);
  assign rasN       = !(state inside {S_RASACT, S_SELFHOLD});
  assign casN       = !(state inside {S_CASLEAD, S_RASACT, S_SELFHOLD});
  assign selfActive = (state == S_SELFHOLD) && timerZero;

  // R3
  cas_before_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> $past(casN) == 1'b0);

  // R6
  ras_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |=> !rasN);

  // R6
  precharge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |=> rasN);

  // R7
  pins_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busReq |-> (rasN && casN));

  // R8
  self_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    selfActive |-> (!rasN && !casN));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int CLK_MHZ       = 100,
  parameter int PAUSE_US      = 200,
  parameter int INIT_CBR      = 8,
  parameter int ROWS          = 1024,
  parameter int PERIOD_MS     = 16,
  parameter int MAX_PEND      = 8,
  parameter int CSR_CYC       = 2,
  parameter int RAS_CYC       = 5,
  parameter int RP_CYC        = 4,
  parameter int SELF_HOLD_CYC = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic selfReq,
  input  logic busGrant,
  output logic busReq,
  output logic rasN,
  output logic casN,
  output logic initDone,
  output logic selfActive
);

  localparam int PAUSE_CYC    = PAUSE_US * CLK_MHZ;
  localparam int INTERVAL_CYC = (PERIOD_MS * 1000 * CLK_MHZ) / ROWS;

  rfshStrobe_t stb;
  logic        timerZero;
  logic        pendAny;

  dram_rfsh_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .selfReq    (selfReq),
    .busGrant   (busGrant),
    .timerZero  (timerZero),
    .pendAny    (pendAny),
    .initDone   (initDone),
    .stb        (stb),
    .busReq     (busReq),
    .rasN       (rasN),
    .casN       (casN),
    .selfActive (selfActive)
  );

  dram_rfsh_dp #(
    .PAUSE_CYC     (PAUSE_CYC),
    .INTERVAL_CYC  (INTERVAL_CYC),
    .INIT_CBR      (INIT_CBR),
    .MAX_PEND      (MAX_PEND),
    .CSR_CYC       (CSR_CYC),
    .RAS_CYC       (RAS_CYC),
    .RP_CYC        (RP_CYC),
    .SELF_HOLD_CYC (SELF_HOLD_CYC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .timerZero (timerZero),
    .pendAny   (pendAny),
    .initDone  (initDone)
  );

endmodule

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;

  localparam int PAUSE_CYC = 200 * 100;
  localparam int IVAL      = (16 * 1000 * 100) / 1024;
  localparam int INIT_N    = 8;
  localparam int PEND_MAX  = 8;
  localparam int CSR       = 2;
  localparam int RASW      = 5;
  localparam int RP        = 4;
  localparam int SELFW     = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selfReq = 1'b0;
  logic busGrant = 1'b0;
  logic busReq, rasN, casN, initDone, selfActive;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int falls = 0;
  int casFallCyc = 0, rasFallCyc = 0, rasRiseCyc = -1000;
  int maxLow = 0;
  bit prevRas = 1'b1, prevCas = 1'b1;
  bit allowGrant = 1'b1;
  bit fastGrant = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dram_refresh_seq uut (
    .clk(clk), .rstN(rstN), .selfReq(selfReq), .busGrant(busGrant),
    .busReq(busReq), .rasN(rasN), .casN(casN),
    .initDone(initDone), .selfActive(selfActive)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit inWindow(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // grant driver
  initial begin
    forever begin
      @(negedge clk);
      if (!busReq) busGrant = 1'b0;
      else if (!busGrant && allowGrant && (fastGrant || ($urandom % 3 == 0)))
        busGrant = 1'b1;
    end
  end

  // strobe monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rstN) begin
        if (prevCas && !casN) casFallCyc = cyc;
        if (prevRas && !rasN) begin
          falls++;
          rasFallCyc = cyc;
          // R3 CAS leads RAS
          check(!casN && (cyc - casFallCyc >= CSR), "R3", cyc - casFallCyc, CSR);
          // R6 precharge before fall
          check(cyc - rasRiseCyc >= RP, "R6 precharge", cyc - rasRiseCyc, RP);
          // R7 strobes only with grant
          check(busGrant == 1'b1, "R7 grant", busGrant, 1);
        end
        if (!prevRas && rasN) begin
          rasRiseCyc = cyc;
          if (cyc - rasFallCyc > maxLow) maxLow = cyc - rasFallCyc;
          check(cyc - rasFallCyc >= RASW, "R6 ras width", cyc - rasFallCyc, RASW);
        end
      end
      prevRas = rasN;
      prevCas = casN;
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int t0, f0, w;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    // R1 reset state
    check(rasN && casN && !busReq && !initDone && !selfActive, "R1 reset",
          {rasN, casN, busReq, initDone, selfActive}, 5'b11000);
    rstN = 1'b1;
    t0 = cyc;
    w = 0;
    while (casN) begin
      @(negedge clk);
      if (busReq && (cyc - t0) < PAUSE_CYC) w++;
    end
    // R1 pause length
    check(cyc - t0 >= PAUSE_CYC, "R1 pause", cyc - t0, PAUSE_CYC);
    check(w == 0, "R1 no request in pause", w, 0);
    while (!initDone) @(negedge clk);
    // R2 init count
    check(falls == INIT_N, "R2 init cycles", falls, INIT_N);

    // R4 average refresh rate, random grant delays
    f0 = falls;
    repeat (16 * IVAL) @(negedge clk);
    check(inWindow(falls - f0, 15, 17), "R4 rate", falls - f0, 16);
    check(initDone, "R2 sticky", initDone, 1);

    // R5/R7 withhold grant
    allowGrant = 1'b0;
    repeat (100) @(negedge clk);
    f0 = falls;
    repeat (12 * IVAL) @(negedge clk);
    check(falls == f0, "R7 no strobes without grant", falls - f0, 0);
    check(busReq && rasN && casN, "R7 request held, pins idle", {busReq, rasN, casN}, 3'b111);
    fastGrant = 1'b1;
    allowGrant = 1'b1;
    f0 = falls;
    repeat (200) @(negedge clk);
    check(inWindow(falls - f0, PEND_MAX, PEND_MAX + 1), "R5 burst capped", falls - f0, PEND_MAX);
    fastGrant = 1'b0;
    repeat (300) @(negedge clk);

    // R8/R9 self refresh with long request
    while (busReq) @(negedge clk);
    selfReq = 1'b1;
    f0 = falls;
    w = 0;
    while (!selfActive && w < 200) begin @(negedge clk); w++; end
    check(selfActive && !rasN && !casN, "R8 self held", {selfActive, rasN, casN}, 3'b100);
    check(cyc - rasFallCyc >= SELFW - 1, "R8 threshold", cyc - rasFallCyc, SELFW - 1);
    repeat (30) @(negedge clk);
    check(!rasN && !casN && selfActive, "R8 hold while requested", {rasN, casN}, 0);
    f0 = falls;
    maxLow = 0;
    selfReq = 1'b0;
    repeat (100) @(negedge clk);
    check(falls - f0 == 1, "R9 one CBR after exit", falls - f0, 1);
    check(!busReq && !selfActive, "R9 release", {busReq, selfActive}, 0);
    f0 = falls;
    repeat (1000) @(negedge clk);
    check(falls == f0, "R9 interval restarted", falls - f0, 0);

    // R8 short request still held past threshold
    while (busReq) @(negedge clk);
    selfReq = 1'b1;
    while (rasN) @(negedge clk);
    selfReq = 1'b0;
    maxLow = 0;
    f0 = falls;
    repeat (100) @(negedge clk);
    check(inWindow(maxLow, SELFW, SELFW + 1), "R8 short hold", maxLow, SELFW);
    check(falls - f0 == 1, "R9 CBR after short self", falls - f0, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule